// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block is the write-only configuration port of an audio converter. A host drives three lines: a data line, a shift clock and a latch strobe, plus an active-low select. Each frame carries a 16-bit word, most significant bit first. The rising latch edge commits the word into a small bank of addressed registers, and the decoded control fields are driven straight out as plain pins. The serial lines run asynchronously to the block clock. They pass through a synchroniser, and their edges are detected in the block clock domain.

The two per-channel attenuation codes are double-buffered. A write stores a staged code. When the write also carries the load flag, both channels take their staged codes into the active set in the same cycle, so left and right can change together. A fifth register, which holds the output pairing mode and the clock-loss detector disable, accepts writes only while the most recent write to the first control register carried an unlock pattern.

There is no streamed data path. Every output is a level that holds until the next committed frame changes it.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset both attenuation outputs are 0xFF and every other output field is 0.
- R2: A frame is shifted MSB first, one bit per rising shift-clock edge, and is committed on the rising latch edge. Word bits [11:9] give the address and bits [8:0] the data. Bits [15:12] have no effect.
- R3: A write to address 000 (left) or 001 (right) with data bit 8 at 0 stores data[7:0] as that channel's staged code and leaves both active attenuation outputs unchanged.
- R4: A write to address 000 or 001 with data bit 8 at 1 makes data[7:0] that channel's active code. In the same cycle the other channel's staged code becomes its active code.
- R5: Address 010 decodes as follows: bit 0 is soft mute, bit 1 is de-emphasis on, bit 2 is DAC output off, and bits [4:3] are the word length.
- R6: Address 011 decodes as follows: bit 0 is I2S format, bit 1 is frame-clock polarity swap, bit 2 is common attenuation, bit 3 is slow roll-off, bit 4 is phase invert, bit 5 is clock-out divide, bits [7:6] are the de-emphasis rate, and bit 8 is zero-detect mute enable.
- R7: While common attenuation is 1, the right attenuation output equals the left active code. While it is 0, the right output is the right active code.
- R8: A frame whose latch edge follows any number of shift-clock edges other than 16 (for example 15 or 17) changes nothing.
- R9: A frame with the select line high changes nothing. While select is high the bit count is cleared.
- R10: Address 110 sets the pairing mode from data[5:4] and the clock-loss disable from data[6]. It is written only when the last write to address 010 had data[8:5] = 1111. Otherwise the write is ignored.
- R11: Writes to addresses 100, 101 and 111 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_latch | input | 1 | Latch strobe, commits on its rising edge |
| ser_cs_n | input | 1 | Active-low select |
| att_left | output | 8 | Left active attenuation code |
| att_right | output | 8 | Right attenuation code after common selection |
| soft_mute | output | 1 | Soft mute request |
| deemph_on | output | 1 | De-emphasis enable |
| dac_off | output | 1 | Force DAC output to zero |
| word_len | output | 2 | Input word-length select |
| fmt_i2s | output | 1 | I2S input format |
| lr_swap | output | 1 | Frame-clock polarity swap |
| att_common | output | 1 | Left code drives both channels |
| slow_filter | output | 1 | Slow roll-off filter select |
| phase_inv | output | 1 | Output phase invert |
| clkout_div | output | 1 | Clock output divide-by-two |
| deemph_rate | output | 2 | De-emphasis sample-rate select |
| zero_mute_en | output | 1 | Zero-detect mute enable |
| diff_mode | output | 2 | Output pairing mode |
| clkloss_off | output | 1 | Clock-loss detector disable |

## Verification
Most faults in the decoded control registers show on the pins as soon as the committing frame is latched. A wrong staged attenuation code stays hidden until the other channel's load flag commits it, so the bench stages codes and then commits them through the opposite channel. A wrong unlock flag or a bad bit count shows only at the next write to address 110 or at the next latch edge. For that reason the bench follows every locked, unlocked, short, long and deselected frame with an output comparison before anything else is sent.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 3;
  localparam int ADDR_LSB   = 9;
  localparam int DATA_W     = 9;
  localparam int ATT_W      = 8;
  localparam int KEEP_BITS  = ADDR_LSB + ADDR_W;
  localparam int UNLOCK_LSB = 5;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_ATT_L = 3'b000,
    ADR_ATT_R = 3'b001,
    ADR_CTL_A = 3'b010,
    ADR_CTL_B = 3'b011,
    ADR_EXT   = 3'b110
  } reg_addr_e;

  typedef struct packed {
    logic       soft_mute;
    logic       deemph_on;
    logic       dac_off;
    logic [1:0] word_len;
    logic       fmt_i2s;
    logic       lr_swap;
    logic       att_common;
    logic       slow_filter;
    logic       phase_inv;
    logic       clkout_div;
    logic [1:0] deemph_rate;
    logic       zero_mute_en;
    logic [1:0] diff_mode;
    logic       clkloss_off;
  } ctrl_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
  parameter int FRAME_BITS = 16,
  parameter int KEEP_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_s,
  input  logic                 sclk_s,
  input  logic                 latch_s,
  input  logic                 csn_s,
  output logic                 wr_valid,
  output logic [KEEP_BITS-1:0] wr_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic                 sclk_prev, latch_prev;
  logic [CNT_W-1:0]     bit_cnt;
  logic [KEEP_BITS-1:0] shreg;
  logic                 sclk_rise, latch_rise;

  assign sclk_rise  = sclk_s & ~sclk_prev;
  assign latch_rise = latch_s & ~latch_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev  <= 1'b0;
      latch_prev <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      wr_valid   <= 1'b0;
      wr_word    <= '0;
    end else begin
      sclk_prev  <= sclk_s;
      latch_prev <= latch_s;
      wr_valid   <= 1'b0;
      if (latch_rise) begin
        wr_valid <= !csn_s && (bit_cnt == CNT_FULL);
        wr_word  <= shreg;
        bit_cnt  <= '0;
      end else if (csn_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[KEEP_BITS-2:0], bit_s};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scr_reg_bank.sv
module scr_reg_bank
  import scr_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int AT_W = ATT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [AT_W-1:0] att_left,
  output logic [AT_W-1:0] att_right,
  output ctrl_t           cfg
);
  localparam int LOAD_BIT = DW - 1;

  logic [AT_W-1:0] stage_l, stage_r, act_l, act_r;
  logic            unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_l  <= '1;
      stage_r  <= '1;
      act_l    <= '1;
      act_r    <= '1;
      cfg      <= '0;
      unlocked <= 1'b0;
    end else if (wr_valid) begin
      case (wr_addr)
        ADR_ATT_L: begin
          stage_l <= wr_data[AT_W-1:0];
          if (wr_data[LOAD_BIT]) begin
            act_l <= wr_data[AT_W-1:0];
            act_r <= stage_r;
          end
        end
        ADR_ATT_R: begin
          stage_r <= wr_data[AT_W-1:0];
          if (wr_data[LOAD_BIT]) begin
            act_r <= wr_data[AT_W-1:0];
            act_l <= stage_l;
          end
        end
        ADR_CTL_A: begin
          cfg.soft_mute <= wr_data[0];
          cfg.deemph_on <= wr_data[1];
          cfg.dac_off   <= wr_data[2];
          cfg.word_len  <= wr_data[4:3];
          unlocked      <= &wr_data[DW-1:UNLOCK_LSB];
        end
        ADR_CTL_B: begin
          cfg.fmt_i2s      <= wr_data[0];
          cfg.lr_swap      <= wr_data[1];
          cfg.att_common   <= wr_data[2];
          cfg.slow_filter  <= wr_data[3];
          cfg.phase_inv    <= wr_data[4];
          cfg.clkout_div   <= wr_data[5];
          cfg.deemph_rate  <= wr_data[7:6];
          cfg.zero_mute_en <= wr_data[8];
        end
        ADR_EXT: begin
          if (unlocked) begin
            cfg.diff_mode   <= wr_data[5:4];
            cfg.clkloss_off <= wr_data[6];
          end
        end
        default: ;
      endcase
    end
  end

  assign att_left  = act_l;
  assign att_right = cfg.att_common ? act_l : act_r;
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data,
  input  logic             ser_clk,
  input  logic             ser_latch,
  input  logic             ser_cs_n,
  output logic [ATT_W-1:0] att_left,
  output logic [ATT_W-1:0] att_right,
  output logic             soft_mute,
  output logic             deemph_on,
  output logic             dac_off,
  output logic [1:0]       word_len,
  output logic             fmt_i2s,
  output logic             lr_swap,
  output logic             att_common,
  output logic             slow_filter,
  output logic             phase_inv,
  output logic             clkout_div,
  output logic [1:0]       deemph_rate,
  output logic             zero_mute_en,
  output logic [1:0]       diff_mode,
  output logic             clkloss_off
);
  logic [3:0]           sync_q;
  logic                 wr_valid;
  logic [KEEP_BITS-1:0] wr_word;
  ctrl_t                cfg;

  scr_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_cs_n, ser_latch, ser_clk, ser_data}),
    .q     (sync_q)
  );

  scr_shifter #(.FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_s    (sync_q[0]),
    .sclk_s   (sync_q[1]),
    .latch_s  (sync_q[2]),
    .csn_s    (sync_q[3]),
    .wr_valid (wr_valid),
    .wr_word  (wr_word)
  );

  scr_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_word[ADDR_LSB +: ADDR_W]),
    .wr_data   (wr_word[DATA_W-1:0]),
    .att_left  (att_left),
    .att_right (att_right),
    .cfg       (cfg)
  );

  assign soft_mute    = cfg.soft_mute;
  assign deemph_on    = cfg.deemph_on;
  assign dac_off      = cfg.dac_off;
  assign word_len     = cfg.word_len;
  assign fmt_i2s      = cfg.fmt_i2s;
  assign lr_swap      = cfg.lr_swap;
  assign att_common   = cfg.att_common;
  assign slow_filter  = cfg.slow_filter;
  assign phase_inv    = cfg.phase_inv;
  assign clkout_div   = cfg.clkout_div;
  assign deemph_rate  = cfg.deemph_rate;
  assign zero_mute_en = cfg.zero_mute_en;
  assign diff_mode    = cfg.diff_mode;
  assign clkloss_off  = cfg.clkloss_off;
endmodule

// File: rtl/serial_ctl_regs_chk.sv
module serial_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       latch_s,
  input logic       csn_s,
  input logic [7:0] att_left,
  input logic [7:0] att_right,
  input logic       soft_mute,
  input logic [1:0] diff_mode,
  input logic       clkloss_off
);
  // R1: reset holds the default values
  assert_reset_defaults_R1: assert property (@(posedge clk)
    !rst_n |=> (att_left == 8'hFF && att_right == 8'hFF && !soft_mute &&
                diff_mode == 2'b00 && !clkloss_off));

  // R2, R9: a commit follows a rising latch seen with select low
  assert_commit_on_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(latch_s) && !$past(latch_s, 2)));

  assert_commit_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(csn_s));

  // R4: active attenuation moves only after a commit
  assert_att_left_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(att_left) |-> $past(wr_valid));

  assert_att_right_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(att_right) |-> $past(wr_valid));

  // R5: mute moves only after a commit
  assert_mute_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(soft_mute) |-> $past(wr_valid));

  // R10: extension fields move only after a commit
  assert_ext_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({diff_mode, clkloss_off}) |-> $past(wr_valid));
endmodule

bind serial_ctl_regs serial_ctl_regs_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .latch_s     (sync_q[2]),
  .csn_s       (sync_q[3]),
  .att_left    (att_left),
  .att_right   (att_right),
  .soft_mute   (soft_mute),
  .diff_mode   (diff_mode),
  .clkloss_off (clkloss_off)
);

// File: tb/serial_ctl_regs_tb_top.sv
module serial_ctl_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0, ser_cs_n = 1'b1;
  logic [7:0] att_left, att_right;
  logic soft_mute, deemph_on, dac_off, fmt_i2s, lr_swap, att_common;
  logic slow_filter, phase_inv, clkout_div, zero_mute_en, clkloss_off;
  logic [1:0] word_len, deemph_rate, diff_mode;

  always #5 clk = ~clk;

  serial_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .ser_cs_n(ser_cs_n),
    .att_left(att_left), .att_right(att_right), .soft_mute(soft_mute),
    .deemph_on(deemph_on), .dac_off(dac_off), .word_len(word_len),
    .fmt_i2s(fmt_i2s), .lr_swap(lr_swap), .att_common(att_common),
    .slow_filter(slow_filter), .phase_inv(phase_inv), .clkout_div(clkout_div),
    .deemph_rate(deemph_rate), .zero_mute_en(zero_mute_en),
    .diff_mode(diff_mode), .clkloss_off(clkloss_off)
  );

  typedef struct {
    logic [32:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_push = 0, n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state, built from the requirements
  logic [7:0] m_stage_l = 8'hFF, m_stage_r = 8'hFF, m_act_l = 8'hFF, m_act_r = 8'hFF;
  logic [4:0] m_c2 = '0;
  logic [8:0] m_c3 = '0;
  logic [1:0] m_diff = '0;
  logic       m_cl = 1'b0, m_unlock = 1'b0;

  function automatic logic [32:0] model_vec();
    return {m_act_l, (m_c3[2] ? m_act_l : m_act_r),
            m_c2[0], m_c2[1], m_c2[2], m_c2[4:3],
            m_c3[0], m_c3[1], m_c3[2], m_c3[3], m_c3[4], m_c3[5], m_c3[7:6], m_c3[8],
            m_diff, m_cl};
  endfunction

  function automatic void model_write(input logic [15:0] w);
    logic [2:0] a;
    logic [8:0] d;
    a = w[11:9];
    d = w[8:0];
    case (a)
      3'b000: begin
        m_stage_l = d[7:0];
        if (d[8]) begin m_act_l = d[7:0]; m_act_r = m_stage_r; end
      end
      3'b001: begin
        m_stage_r = d[7:0];
        if (d[8]) begin m_act_r = d[7:0]; m_act_l = m_stage_l; end
      end
      3'b010: begin m_c2 = d[4:0]; m_unlock = &d[8:5]; end
      3'b011: m_c3 = d;
      3'b110: if (m_unlock) begin m_diff = d[5:4]; m_cl = d[6]; end
      default: ;
    endcase
  endfunction

  task automatic push(input string tag);
    item_t it;
    it.exp = model_vec();
    it.tag = tag;
    q.push_back(it);
    n_push++;
    repeat (3) @(posedge clk);
  endtask

  // driver: shifts n bits MSB first, latches, then pushes the expected outputs
  task automatic send(input logic [31:0] bits, input int n, input logic cs_n,
                      input bit takes_effect, input string tag);
    @(posedge clk);
    ser_cs_n = cs_n;
    repeat (2) @(posedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      repeat (2) @(posedge clk);
      ser_clk = 1'b1;
      repeat (2) @(posedge clk);
      ser_clk = 1'b0;
    end
    repeat (2) @(posedge clk);
    ser_latch = 1'b1;
    repeat (2) @(posedge clk);
    ser_latch = 1'b0;
    repeat (2) @(posedge clk);
    ser_cs_n = 1'b1;
    repeat (8) @(posedge clk);
    if (takes_effect) model_write(bits[15:0]);
    push(tag);
  endtask

  // monitor: pops expected items and compares on the falling edge
  initial begin
    forever begin
      item_t it;
      logic [32:0] act;
      wait (n_push > n_cmp);
      @(negedge clk);
      it = q.pop_front();
      act = {att_left, att_right, soft_mute, deemph_on, dac_off, word_len,
             fmt_i2s, lr_swap, att_common, slow_filter, phase_inv, clkout_div,
             deemph_rate, zero_mute_en, diff_mode, clkloss_off};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    push("R1 reset defaults");

    send(32'h0040, 16, 1'b0, 1'b1, "R3 left staged, active unchanged");
    send(32'h0230, 16, 1'b0, 1'b1, "R3 right staged, active unchanged");
    send(32'h0320, 16, 1'b0, 1'b1, "R4 right load commits both channels");
    send(32'h0111, 16, 1'b0, 1'b1, "R4 left load commits both channels");
    send(32'hF405, 16, 1'b0, 1'b1, "R2 top bits ignored; R5 mute and dac off");
    send(32'h0418, 16, 1'b0, 1'b1, "R5 word length field");
    send(32'h07A5, 16, 1'b0, 1'b1, "R6 second control fields; R7 common on");
    send(32'h0600, 16, 1'b0, 1'b1, "R7 common off restores right code");
    send(32'h0C70, 16, 1'b0, 1'b1, "R10 locked write ignored");
    send(32'h05E0, 16, 1'b0, 1'b1, "R10 unlock pattern written");
    send(32'h0C70, 16, 1'b0, 1'b1, "R10 unlocked write accepted");
    send(32'h0401, 16, 1'b0, 1'b1, "R10 relock by plain write");
    send(32'h0C10, 16, 1'b0, 1'b1, "R10 write after relock ignored");
    send(32'h0155, 15, 1'b0, 1'b0, "R8 short frame discarded");
    send(32'h00155, 17, 1'b0, 1'b0, "R8 long frame discarded");
    send(32'h0155, 16, 1'b1, 1'b0, "R9 deselected frame discarded");
    send(32'h08FF, 16, 1'b0, 1'b1, "R11 address 100 ignored");
    send(32'h0AFF, 16, 1'b0, 1'b1, "R11 address 101 ignored");
    send(32'h0EFF, 16, 1'b0, 1'b1, "R11 address 111 ignored");
    send(32'h0155, 16, 1'b0, 1'b1, "R2 R4 valid frame after discards");

    wait (n_cmp == n_push);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule